// File: doc/BRIEF.md
# Interrupt queue and nesting controller

This block decides how a new interrupt is handled while another one is in service. It watches level-held external request lines, one-cycle internal cause strobes raised by instructions, and a strobe that marks the end of the running handler. Each new event is started at once, nested over the running handler, parked in a small pending queue, ignored for now, or turned into a fatal stop. A nested interrupt suspends the running context on a context stack until the nested handler completes. A queued one waits until nothing is in service.

A static configuration input chooses, for an external event that arrives during handling, whether it nests or is queued. A second configuration input selects the simplified regime: external requests are held off for the whole time a handler runs, and an internal cause during handling is fatal. Internal causes are accepted in any cycle. External requests are looked at only in cycles flagged as instruction boundaries. Handler vector lookup and saving of architectural state belong to the neighbouring logic.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `take_o`, `ext_ack_o`, `active_o`, `depth_o` and `fatal_o` are all zero.
- R2: An external request is acted on only in a cycle where `boundary_i` is 1. An internal strobe is acted on in any cycle. Decisions show on `take_o`, `take_cause_o` and `ext_ack_o` in the same cycle as the inputs that cause them.
- R3: The cause code is {MSB = 1 for internal and 0 for external, low bits = line index}. When several lines of one kind are raised together, the lowest index wins. An internal strobe beats any external request in the same cycle, and that external request gets no acknowledge.
- R4: An internal strobe during handling (normal regime) pulses `take_o` and pushes the running context. `depth_o` rises by one, and `active_cause_o` shows the new cause from the next cycle.
- R5: An external request during handling (normal regime) is acknowledged with a one-hot `ext_ack_o` bit. It nests and pulses `take_o` when `nest_ext_i` = 1. It is queued with no take pulse when `nest_ext_i` = 0.
- R6: With the pending queue full, a request that would be queued gets no acknowledge and no take.
- R7: `done_i` with `depth_o` > 0 restores the most recently suspended cause to `active_cause_o` and lowers `depth_o` by one, with no take pulse.
- R8: `done_i` with `depth_o` = 0 ends handling. Queued causes are then dispatched oldest first, one in each boundary cycle in which nothing is in service, with `take_o` and no acknowledge. Such a dispatch never happens in the cycle of `done_i`.
- R9: Nesting when `depth_o` already equals NEST_MAX sets `fatal_o` and gives no take.
- R10: Once `fatal_o` is set, it stays set until reset, and no take or acknowledge is produced.
- R11: With `simple_mode_i` = 1 during handling, external requests are neither acknowledged nor taken, and an internal strobe sets `fatal_o` with no take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_req_i | input | NUM_EXT | External request levels, held until acknowledged |
| int_strobe_i | input | NUM_INT | Internal cause strobes, one cycle wide |
| boundary_i | input | 1 | Instruction boundary: the pipeline advances this cycle |
| done_i | input | 1 | Running handler has finished |
| nest_ext_i | input | 1 | 1: external during handling nests, 0: it is queued |
| simple_mode_i | input | 1 | Simplified regime: externals masked while handling, internal is fatal |
| take_o | output | 1 | Start a handler this cycle |
| take_cause_o | output | CW | Cause of the handler being started |
| ext_ack_o | output | NUM_EXT | One-hot acknowledge of an external request |
| active_o | output | 1 | A handler is in service |
| active_cause_o | output | CW | Cause of the handler in service |
| depth_o | output | DW | Number of suspended contexts |
| fatal_o | output | 1 | Sticky fatal stop |

## Verification
The bench builds the block with four external lines, four internal lines, a queue of two and a nesting limit of two. With these small limits it fills the pending queue and reaches the nesting overflow in a few cycles. The same run also covers queue refusal, ordered dispatch after the queue has filled and drained, and the fatal stop. Four lines of each kind are enough to show lowest-index selection, and to show that an internal strobe beats an external request in the same cycle.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  typedef enum logic [2:0] {
    EV_NONE,
    EV_TAKE,      // nothing in service
    EV_NEST,      // preempt running context
    EV_QUEUE,     // park external request
    EV_DISPATCH,  // start oldest parked request
    EV_FATAL
  } irq_ev_e;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = |req_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irq_fifo.sv
module irq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 3,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]    mem [DEPTH];
  logic [PW-1:0]   rd_q, wr_q;
  logic [CNTW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign head_o  = mem[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNTW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + CNTW'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CNTW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_q] <= din_i;
  end
endmodule

// File: rtl/irq_ctx_stack.sv
module irq_ctx_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 3,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [W-1:0]    din_i,
  output logic [W-1:0]    top_o,
  output logic [CNTW-1:0] count_o,
  output logic            empty_o,
  output logic            full_o
);
  logic [W-1:0]    mem [DEPTH];
  logic [CNTW-1:0] cnt_q, cm1;

  assign cm1     = cnt_q - CNTW'(1);
  assign top_o   = mem[cm1[PW-1:0]];
  assign count_o = cnt_q;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNTW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (push_i && !pop_i) cnt_q <= cnt_q + CNTW'(1);
    else if (pop_i && !push_i) cnt_q <= cm1;
  end

  // push with pop replaces the top entry
  always_ff @(posedge clk_i) begin
    if (push_i && pop_i) mem[cm1[PW-1:0]]   <= din_i;
    else if (push_i)     mem[cnt_q[PW-1:0]] <= din_i;
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int NUM_EXT     = 4,
  parameter int NUM_INT     = 4,
  parameter int QUEUE_DEPTH = 4,
  parameter int NEST_MAX    = 4,
  localparam int MAXN = (NUM_EXT > NUM_INT) ? NUM_EXT : NUM_INT,
  localparam int IW   = (MAXN > 1) ? $clog2(MAXN) : 1,
  localparam int CW   = IW + 1,
  localparam int DW   = $clog2(NEST_MAX + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXT-1:0] ext_req_i,
  input  logic [NUM_INT-1:0] int_strobe_i,
  input  logic               boundary_i,
  input  logic               done_i,
  input  logic               nest_ext_i,
  input  logic               simple_mode_i,
  output logic               take_o,
  output logic [CW-1:0]      take_cause_o,
  output logic [NUM_EXT-1:0] ext_ack_o,
  output logic               active_o,
  output logic [CW-1:0]      active_cause_o,
  output logic [DW-1:0]      depth_o,
  output logic               fatal_o
);
  logic          int_v, ext_v;
  logic [IW-1:0] int_idx, ext_idx;
  logic          busy_q, fatal_q;
  logic [CW-1:0] cur_q;
  logic          busy_a, room_a;
  logic [CW-1:0] cur_a, new_cause;
  irq_ev_e       ev;

  logic          q_push, q_pop, q_empty, q_full;
  logic [CW-1:0] q_head;
  logic          stk_push, stk_pop, stk_empty, stk_full;
  logic [CW-1:0] stk_top;

  irq_pick #(.N(NUM_INT), .IW(IW)) u_pick_int (
    .req_i(int_strobe_i), .valid_o(int_v), .idx_o(int_idx));
  irq_pick #(.N(NUM_EXT), .IW(IW)) u_pick_ext (
    .req_i(ext_req_i), .valid_o(ext_v), .idx_o(ext_idx));

  irq_fifo #(.DEPTH(QUEUE_DEPTH), .W(CW)) u_queue (
    .clk_i, .rst_ni, .push_i(q_push), .din_i(new_cause), .pop_i(q_pop),
    .head_o(q_head), .empty_o(q_empty), .full_o(q_full));

  irq_ctx_stack #(.DEPTH(NEST_MAX), .W(CW)) u_stack (
    .clk_i, .rst_ni, .push_i(stk_push), .pop_i(stk_pop), .din_i(cur_a),
    .top_o(stk_top), .count_o(depth_o), .empty_o(stk_empty), .full_o(stk_full));

  always_comb begin
    // completion is applied before new arrivals of the same cycle
    busy_a  = busy_q;
    cur_a   = cur_q;
    stk_pop = 1'b0;
    if (done_i && busy_q && !fatal_q) begin
      if (stk_empty) busy_a = 1'b0;
      else begin
        stk_pop = 1'b1;
        cur_a   = stk_top;
      end
    end
    room_a = !stk_full || stk_pop;

    ev        = EV_NONE;
    new_cause = '0;
    if (!fatal_q) begin
      if (int_v) begin
        new_cause = {1'b1, int_idx};
        if (!busy_a)                     ev = EV_TAKE;
        else if (simple_mode_i || !room_a) ev = EV_FATAL;
        else                             ev = EV_NEST;
      end else if (boundary_i) begin
        if (!busy_a && !q_empty) begin
          if (!busy_q) begin
            ev        = EV_DISPATCH;
            new_cause = q_head;
          end
        end else if (ext_v) begin
          new_cause = {1'b0, ext_idx};
          if (!busy_a)            ev = EV_TAKE;
          else if (simple_mode_i) ev = EV_NONE;
          else if (nest_ext_i)    ev = room_a ? EV_NEST : EV_FATAL;
          else if (!q_full)       ev = EV_QUEUE;
        end
      end
    end
  end

  assign take_o       = (ev == EV_TAKE) || (ev == EV_NEST) || (ev == EV_DISPATCH);
  assign take_cause_o = take_o ? new_cause : '0;
  assign stk_push     = (ev == EV_NEST);
  assign q_push       = (ev == EV_QUEUE);
  assign q_pop        = (ev == EV_DISPATCH);
  assign ext_ack_o    = (!new_cause[CW-1] &&
                         ((ev == EV_TAKE) || (ev == EV_NEST) || (ev == EV_QUEUE)))
                        ? (NUM_EXT'(1) << ext_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cur_q   <= '0;
      fatal_q <= 1'b0;
    end else begin
      busy_q <= busy_a || take_o;
      cur_q  <= take_o ? new_cause : cur_a;
      if (ev == EV_FATAL) fatal_q <= 1'b1;
    end
  end

  assign active_o       = busy_q;
  assign active_cause_o = cur_q;
  assign fatal_o        = fatal_q;
endmodule

// File: rtl/irq_nest_checker.sv
module irq_nest_checker #(
  parameter int NUM_EXT  = 4,
  parameter int NUM_INT  = 4,
  parameter int NEST_MAX = 4,
  localparam int MAXN = (NUM_EXT > NUM_INT) ? NUM_EXT : NUM_INT,
  localparam int IW   = (MAXN > 1) ? $clog2(MAXN) : 1,
  localparam int CW   = IW + 1,
  localparam int DW   = $clog2(NEST_MAX + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EXT-1:0] ext_req_i,
  input logic [NUM_INT-1:0] int_strobe_i,
  input logic               boundary_i,
  input logic               done_i,
  input logic               simple_mode_i,
  input logic               take_o,
  input logic [CW-1:0]      take_cause_o,
  input logic [NUM_EXT-1:0] ext_ack_o,
  input logic               active_o,
  input logic [DW-1:0]      depth_o,
  input logic               fatal_o
);
  AST_EXT_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !take_cause_o[CW-1]) |-> boundary_i); // R2
  AST_INT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((int_strobe_i != '0) && take_o) |-> (take_cause_o[CW-1] && ext_ack_o == '0)); // R3
  AST_ACK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ext_ack_o) && ((ext_ack_o & ~ext_req_i) == '0)); // R5
  AST_NEST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && active_o && !done_i) |=> (depth_o == DW'($past(depth_o) + 1'b1))); // R4
  AST_DEPTH_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= DW'(NEST_MAX)); // R9
  AST_FATAL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> fatal_o); // R10
  AST_FATAL_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |-> (!take_o && ext_ack_o == '0)); // R10
  AST_SIMPLE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (simple_mode_i && active_o && !done_i) |-> (ext_ack_o == '0)); // R11
endmodule

bind irq_nest_ctrl irq_nest_checker #(
  .NUM_EXT(NUM_EXT), .NUM_INT(NUM_INT), .NEST_MAX(NEST_MAX)
) u_chk (.*);

// File: tb/irq_nest_ctrl_bench.sv
`timescale 1ns/1ps
module irq_nest_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ext_req = '0, int_strobe = '0, ext_ack;
  logic       boundary = 1'b0, done = 1'b0, nest_ext = 1'b0, simple = 1'b0;
  logic       take, active, fatal;
  logic [2:0] take_cause, active_cause;
  logic [1:0] depth;

  int nvec = 0, nmis = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  irq_nest_ctrl #(.NUM_EXT(4), .NUM_INT(4), .QUEUE_DEPTH(2), .NEST_MAX(2)) u_irq_nest_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ext_req_i(ext_req), .int_strobe_i(int_strobe),
    .boundary_i(boundary), .done_i(done), .nest_ext_i(nest_ext), .simple_mode_i(simple),
    .take_o(take), .take_cause_o(take_cause), .ext_ack_o(ext_ack), .active_o(active),
    .active_cause_o(active_cause), .depth_o(depth), .fatal_o(fatal));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nmis++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_take(input string tag, input logic [2:0] c);
    exp_q.push_back(c);
    tag_q.push_back(tag);
  endtask

  task automatic step(input logic [3:0] e, input logic [3:0] i, input logic b, input logic d);
    @(negedge clk);
    ext_req = e; int_strobe = i; boundary = b; done = d;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ext_req = '0; int_strobe = '0; boundary = 1'b0; done = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor: every take pulse is matched against the scoreboard
  always begin
    @(negedge clk);
    #1;
    if (rst_n && take) begin
      nvec++;
      if (exp_q.size() == 0) begin
        nmis++;
        $display("FAIL unexpected take: got %0h expected none", take_cause);
      end else begin
        automatic logic [2:0] c = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (take_cause !== c) begin
          nmis++;
          $display("FAIL %s take cause: got %0h expected %0h", t, take_cause, c);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    nmis++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

  initial begin
    do_reset();
    step(4'b0000, 4'b0000, 0, 0);
    chk("R1 take", 8'(take), 8'h0);
    chk("R1 ack", 8'(ext_ack), 8'h0);
    chk("R1 active", 8'(active), 8'h0);
    chk("R1 depth", 8'(depth), 8'h0);
    chk("R1 fatal", 8'(fatal), 8'h0);
    // R2 external waits for a boundary
    step(4'b0001, 4'b0000, 0, 0);
    chk("R2 no ack off boundary", 8'(ext_ack), 8'h0);
    chk("R2 no take off boundary", 8'(take), 8'h0);
    // R3 lowest external index wins
    expect_take("R3", 3'b000);
    step(4'b0011, 4'b0000, 1, 0);
    chk("R3 ack lowest", 8'(ext_ack), 8'h1);
    // R4 internal nests mid-instruction
    expect_take("R4", 3'b110);
    step(4'b0010, 4'b0100, 0, 0);
    chk("R4 active before", 8'(active), 8'h1);
    // R5 queue on internal handler
    step(4'b1010, 4'b0000, 1, 0);
    chk("R4 depth", 8'(depth), 8'h1);
    chk("R4 active cause", 8'(active_cause), 8'h6);
    chk("R5 queue ack", 8'(ext_ack), 8'h2);
    chk("R5 queue no take", 8'(take), 8'h0);
    step(4'b1000, 4'b0000, 1, 0);
    chk("R5 second queue ack", 8'(ext_ack), 8'h8);
    step(4'b0100, 4'b0000, 1, 0);
    chk("R6 full no ack", 8'(ext_ack), 8'h0);
    // R7 resume suspended context
    step(4'b0100, 4'b0000, 0, 1);
    chk("R7 no take on resume", 8'(take), 8'h0);
    step(4'b0100, 4'b0000, 0, 0);
    chk("R7 depth", 8'(depth), 8'h0);
    chk("R7 resumed cause", 8'(active_cause), 8'h0);
    chk("R7 still active", 8'(active), 8'h1);
    // R8 dispatch after last done
    step(4'b0100, 4'b0000, 1, 1);
    chk("R8 no dispatch in done cycle", 8'(take), 8'h0);
    expect_take("R8 oldest", 3'b001);
    step(4'b0100, 4'b0000, 1, 0);
    chk("R8 no ack in dispatch", 8'(ext_ack), 8'h0);
    step(4'b0100, 4'b0000, 1, 0);
    chk("R5 queue after dispatch", 8'(ext_ack), 8'h4);
    step(4'b0000, 4'b0000, 0, 1);
    expect_take("R8 second", 3'b011);
    step(4'b0000, 4'b0000, 1, 0);
    step(4'b0000, 4'b0000, 0, 1);
    expect_take("R8 third", 3'b010);
    step(4'b0000, 4'b0000, 1, 0);
    step(4'b0000, 4'b0000, 0, 1);
    // R3 internal beats external
    expect_take("R3 internal first", 3'b111);
    step(4'b0001, 4'b1000, 1, 0);
    chk("R3 external not acked", 8'(ext_ack), 8'h0);
    // R5 nesting of externals
    nest_ext = 1'b1;
    expect_take("R5 nest on internal", 3'b000);
    step(4'b0001, 4'b0000, 1, 0);
    chk("R5 nest ack", 8'(ext_ack), 8'h1);
    expect_take("R5 nest on external", 3'b001);
    step(4'b0010, 4'b0000, 1, 0);
    // R9 overflow
    step(4'b0000, 4'b0001, 0, 0);
    chk("R9 depth at limit", 8'(depth), 8'h2);
    chk("R9 no take", 8'(take), 8'h0);
    step(4'b0100, 4'b0010, 1, 0);
    chk("R9 fatal", 8'(fatal), 8'h1);
    chk("R10 no take", 8'(take), 8'h0);
    chk("R10 no ack", 8'(ext_ack), 8'h0);
    step(4'b0000, 4'b0000, 0, 0);
    chk("R10 sticky", 8'(fatal), 8'h1);
    // R11 simplified regime
    simple = 1'b1;
    do_reset();
    expect_take("R11 first", 3'b000);
    step(4'b0001, 4'b0000, 1, 0);
    step(4'b0010, 4'b0000, 1, 0);
    chk("R11 masked ack", 8'(ext_ack), 8'h0);
    chk("R11 masked take", 8'(take), 8'h0);
    step(4'b0010, 4'b0001, 0, 0);
    chk("R11 internal no take", 8'(take), 8'h0);
    step(4'b0000, 4'b0000, 0, 0);
    chk("R11 fatal", 8'(fatal), 8'h1);
    chk("R11 queue unused", 8'(exp_q.size()), 8'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end
endmodule